// File: doc/BRIEF.md
# Dual-Clock Nine-Bit FIFO with Reset-Selected Auxiliary Write Pin

This block is a first-in first-out buffer for 9-bit words. It has separate write and read clocks and a registered output stage. A write lands when the primary active-low write enable is low on a write-clock edge. A second pin, `wr_aux`, also takes part, and its job is fixed by the level it holds while reset is asserted:

- **Held high in reset:** it is a second active-low write enable. A write then needs both enables low.
- **Held low in reset:** it becomes a load strobe. With the primary enable also low, the data input goes into two flag-offset registers instead of the memory. While the strobe is held low, read strobes bring those registers out on the data bus, one after the other.

The read side pops a word only when both active-low read enables are low and the buffer holds data. The output register changes on nothing else. The empty indication is active low and belongs to the read clock. The write pointer reaches the read side as a Gray code through two flops, so the flag rises one or two read edges after the first write into an empty buffer. A read can take effect only from the edge after the flag rises, however early the read enables were pulled low. The three-state output is modelled as a data bus plus a drive-enable that follows the active-low output enable.

Top module: `dual_clk_fifo`

## Requirements
- R1: While `rst_n` is low, with both clocks running, `empty_n` is 0 and `q_data` is all zeros; after release they stay so until a word is written and read.
- R2: In enable mode (`wr_aux` high during reset), a word is stored only on a write-clock edge where `wr_en_n` and `wr_aux` are both 0; either one alone stores nothing.
- R3: In load mode (`wr_aux` low during reset), an edge with `wr_en_n`=0 and `wr_aux`=0 writes `d_in` into offset register 0, then 1, alternating, and leaves the FIFO contents unchanged. An edge with `wr_en_n`=0 and `wr_aux`=1 stores a FIFO word.
- R4: In load mode, while `wr_aux` has been low for at least two read edges, a read edge with both read enables low loads offset register 0, then 1, alternating, into `q_data` without popping the FIFO.
- R5: `q_drive` equals the inverse of `out_en_n` at all times, including during reset.
- R6: After a write into an empty FIFO, `empty_n` rises on the first or second read-clock edge following that write edge.
- R7: A read edge while `empty_n` is 0 leaves `q_data` unchanged, so the first word appears on the read edge after `empty_n` rises, even if the read enables were already low.
- R8: A read edge with only one of `rd_en_a_n` or `rd_en_b_n` low leaves `q_data` and the FIFO unchanged.
- R9: Enabled reads of a non-empty FIFO put the stored words on `q_data` in write order, one per read edge, and `empty_n` falls on the edge that reads the last word.
- R10: With `DEPTH` words stored, further writes are dropped and the stored words read back intact.
- R11: Both offset registers hold `OFS_INIT` (default 7) after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| rst_n | input | 1 | Active-low reset for both domains |
| d_in | input | 9 | Write data |
| wr_en_n | input | 1 | Primary write enable, active low |
| wr_aux | input | 1 | Second write enable or offset load strobe, chosen during reset |
| rd_en_a_n | input | 1 | First read enable, active low |
| rd_en_b_n | input | 1 | Second read enable, active low |
| out_en_n | input | 1 | Output enable, active low |
| q_data | output | 9 | Registered read data |
| q_drive | output | 1 | High when `q_data` is driven; low means high impedance |
| empty_n | output | 1 | Empty flag in the read domain, active low |

## Verification
Write strobes are tried with the primary enable alone, the auxiliary pin alone and both together. Only the last may change what is read back. The same split is applied to the two read enables. One test holds the read enables low before the very first write, which separates a flag that only rises from a read that jumps ahead of it. Filling past the depth and draining shows dropped writes apart from corrupted ones. Load-mode runs read the offsets before and after loading, which separates the reset value, the alternation order and any spill of the load strobe into the FIFO.

// File: rtl/dual_clk_fifo.sv
`timescale 1ns/100ps
module dual_clk_fifo #(
  parameter int W = 9,
  parameter int DEPTH = 64,
  parameter logic [W-1:0] OFS_INIT = 9'd7
) (
  input  logic         wr_clk,
  input  logic         rd_clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  input  logic         wr_en_n,
  input  logic         wr_aux,
  input  logic         rd_en_a_n,
  input  logic         rd_en_b_n,
  input  logic         out_en_n,
  output logic [W-1:0] q_data,
  output logic         q_drive,
  output logic         empty_n
);
  localparam int AW = $clog2(DEPTH);

  function automatic logic [AW:0] to_gray(input logic [AW:0] b);
    return b ^ (b >> 1);
  endfunction

  logic          mode_ld;
  logic [W-1:0]  mem [DEPTH];
  logic [W-1:0]  ofs [2];
  logic          osel_w, osel_r;
  logic [AW:0]   wbin, wgray, rq1, rq2;
  logic [AW:0]   rbin, rgray, wq1, wq2;
  logic          ld1, ld2;
  logic [W-1:0]  q;

  always_ff @(posedge wr_clk)
    if (!rst_n) mode_ld <= ~wr_aux;

  wire fifo_we = ~wr_en_n & (mode_ld ? wr_aux : ~wr_aux);
  wire ofs_we  = ~wr_en_n & mode_ld & ~wr_aux;
  wire full    = (wgray == {~rq2[AW:AW-1], rq2[AW-2:0]});
  wire push    = fifo_we & ~full;
  wire [AW:0] wbin_nx = wbin + {{AW{1'b0}}, push};

  always_ff @(posedge wr_clk or negedge rst_n)
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
      rq1   <= '0;
      rq2   <= '0;
    end else begin
      wbin  <= wbin_nx;
      wgray <= to_gray(wbin_nx);
      rq1   <= rgray;
      rq2   <= rq1;
    end

  always_ff @(posedge wr_clk)
    if (push) mem[wbin[AW-1:0]] <= d_in;

  always_ff @(posedge wr_clk or negedge rst_n)
    if (!rst_n) begin
      ofs[0] <= OFS_INIT;
      ofs[1] <= OFS_INIT;
      osel_w <= 1'b0;
    end else if (ofs_we) begin
      ofs[osel_w] <= d_in;
      osel_w      <= ~osel_w;
    end

  wire ld_raw = mode_ld & ~wr_aux;
  wire ren    = ~rd_en_a_n & ~rd_en_b_n;
  wire ofs_rd = ld2 & ren;
  wire pop    = ren & ~ld2 & empty_n;
  wire [AW:0] rbin_nx = rbin + {{AW{1'b0}}, pop};

  always_ff @(posedge rd_clk or negedge rst_n)
    if (!rst_n) begin
      rbin   <= '0;
      rgray  <= '0;
      wq1    <= '0;
      wq2    <= '0;
      ld1    <= 1'b0;
      ld2    <= 1'b0;
      osel_r <= 1'b0;
      q      <= '0;
    end else begin
      rbin  <= rbin_nx;
      rgray <= to_gray(rbin_nx);
      wq1   <= wgray;
      wq2   <= wq1;
      ld1   <= ld_raw;
      ld2   <= ld1;
      if (ofs_rd) begin
        q      <= ofs[osel_r];
        osel_r <= ~osel_r;
      end else if (pop) begin
        q <= mem[rbin[AW-1:0]];
      end
    end

  assign empty_n = (rgray != wq2);
  assign q_data  = q;
  assign q_drive = ~out_en_n;
endmodule

// File: rtl/dual_clk_fifo_chk.sv
`timescale 1ns/100ps
module dual_clk_fifo_chk #(
  parameter int W = 9,
  parameter int AW = 6
) (
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          rst_n,
  input logic          mode_ld,
  input logic          wr_aux,
  input logic          full,
  input logic [AW:0]   wbin,
  input logic [AW:0]   rbin,
  input logic          rd_en_a_n,
  input logic          rd_en_b_n,
  input logic          ld2,
  input logic          empty_n,
  input logic [W-1:0]  q
);
  always @(posedge rd_clk)
    if (!rst_n) p_reset_clear_r1: assert (!empty_n && q == '0);

  p_ld_no_push_r3: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (mode_ld && !wr_aux) |=> $stable(wbin));

  p_ofs_read_no_pop_r4: assert property (@(posedge rd_clk) disable iff (!rst_n)
    ld2 |=> $stable(rbin));

  p_empty_holds_q_r7: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (!empty_n && !ld2) |=> $stable(q));

  p_single_ren_r8: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (rd_en_a_n || rd_en_b_n) |=> ($stable(q) && $stable(rbin)));

  p_no_overflow_r10: assert property (@(posedge wr_clk) disable iff (!rst_n)
    full |=> $stable(wbin));
endmodule

bind dual_clk_fifo dual_clk_fifo_chk #(.W(W), .AW(AW)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .mode_ld(mode_ld),
  .wr_aux(wr_aux), .full(full), .wbin(wbin), .rbin(rbin),
  .rd_en_a_n(rd_en_a_n), .rd_en_b_n(rd_en_b_n), .ld2(ld2),
  .empty_n(empty_n), .q(q)
);

// File: tb/dual_clk_fifo_tb.sv
`timescale 1ns/100ps
module dual_clk_fifo_tb;
  localparam int DEPTH = 64;

  logic wr_clk = 0, rd_clk = 0, rst_n = 0;
  logic [8:0] d_in = '0;
  logic wr_en_n = 1, wr_aux = 1, rd_en_a_n = 1, rd_en_b_n = 1, out_en_n = 0;
  logic [8:0] q_data;
  logic q_drive, empty_n;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 wr_clk = ~wr_clk;
  initial begin
    #1.5;
    forever #2.5 rd_clk = ~rd_clk;
  end

  dual_clk_fifo #(.DEPTH(DEPTH)) u_dut (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .d_in(d_in),
    .wr_en_n(wr_en_n), .wr_aux(wr_aux), .rd_en_a_n(rd_en_a_n),
    .rd_en_b_n(rd_en_b_n), .out_en_n(out_en_n), .q_data(q_data),
    .q_drive(q_drive), .empty_n(empty_n)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input bit load_mode);
    @(negedge wr_clk);
    rst_n = 0; wr_en_n = 1; rd_en_a_n = 1; rd_en_b_n = 1;
    wr_aux = load_mode ? 1'b0 : 1'b1;
    repeat (6) @(negedge wr_clk);
    chk("R1 empty_n in reset", empty_n, 0);
    chk("R1 q_data in reset", q_data, 0);
    rst_n = 1;
    wr_aux = 1;
    repeat (3) @(negedge rd_clk);
  endtask

  task automatic wr_word(input logic [8:0] d, input logic a_n, input logic aux, input logic aux_after);
    @(negedge wr_clk);
    d_in = d; wr_en_n = a_n; wr_aux = aux;
    @(negedge wr_clk);
    wr_en_n = 1; wr_aux = aux_after;
  endtask

  task automatic rd_pulse(input logic a_n, input logic b_n);
    @(negedge rd_clk);
    rd_en_a_n = a_n; rd_en_b_n = b_n;
    @(negedge rd_clk);
    rd_en_a_n = 1; rd_en_b_n = 1;
  endtask

  task automatic t_reset_state;
    do_reset(0);
    out_en_n = 0; #0.5;
    chk("R5 q_drive with out_en_n low", q_drive, 1);
    chk("R1 q_data after reset", q_data, 0);
    chk("R1 empty_n after reset", empty_n, 0);
    out_en_n = 1; #0.5;
    chk("R5 q_drive with out_en_n high", q_drive, 0);
    out_en_n = 0;
  endtask

  task automatic t_first_word;
    int n;
    do_reset(0);
    @(negedge rd_clk);
    rd_en_a_n = 0; rd_en_b_n = 0;
    @(negedge wr_clk);
    d_in = 9'h0A5; wr_en_n = 0; wr_aux = 0;
    @(posedge wr_clk);
    #1; wr_en_n = 1; wr_aux = 1;
    n = 0;
    for (int i = 0; i < 4; i++) begin
      @(posedge rd_clk); #0.5;
      n++;
      if (empty_n) break;
    end
    chk("R6 empty_n rose", empty_n, 1);
    chk("R6 read edges to flag within two", (n >= 1 && n <= 2) ? 1 : 0, 1);
    chk("R7 q_data held while empty", q_data, 0);
    @(posedge rd_clk); #0.5;
    chk("R7 first word after flag", q_data, 9'h0A5);
    chk("R9 empty_n after last word", empty_n, 0);
    rd_en_a_n = 1; rd_en_b_n = 1;
  endtask

  task automatic t_dual_enable;
    do_reset(0);
    wr_word(9'h0AA, 0, 1, 1);
    wr_word(9'h0BB, 1, 0, 1);
    repeat (4) @(negedge rd_clk);
    chk("R2 single write enable stores nothing", empty_n, 0);
    wr_word(9'h101, 0, 0, 1);
    wr_word(9'h055, 0, 0, 1);
    wr_word(9'h1FF, 0, 0, 1);
    repeat (4) @(negedge rd_clk);
    chk("R2 dual-enable write sets flag", empty_n, 1);
    rd_pulse(0, 1);
    chk("R8 only enable a", q_data, 0);
    rd_pulse(1, 0);
    chk("R8 only enable b", q_data, 0);
    rd_pulse(0, 0);
    chk("R9 word 0", q_data, 9'h101);
    rd_pulse(0, 0);
    chk("R9 word 1", q_data, 9'h055);
    chk("R9 still non-empty", empty_n, 1);
    rd_pulse(0, 0);
    chk("R9 word 2", q_data, 9'h1FF);
    chk("R9 empty after drain", empty_n, 0);
    rd_pulse(0, 0);
    chk("R7 read of empty keeps q", q_data, 9'h1FF);
  endtask

  task automatic t_full;
    int bad;
    do_reset(0);
    for (int i = 0; i < DEPTH + 3; i++) wr_word(9'((i * 5 + 1) & 9'h1FF), 0, 0, 1);
    repeat (4) @(negedge rd_clk);
    bad = 0;
    for (int i = 0; i < DEPTH; i++) begin
      rd_pulse(0, 0);
      if (q_data != 9'((i * 5 + 1) & 9'h1FF)) begin
        bad++;
        chk("R10 stored word", q_data, (i * 5 + 1) & 9'h1FF);
      end
    end
    chk("R10 mismatching words", bad, 0);
    chk("R10 extra writes dropped", empty_n, 0);
  endtask

  task automatic t_load_mode;
    do_reset(1);
    @(negedge wr_clk); wr_aux = 0;
    repeat (3) @(negedge rd_clk);
    rd_pulse(0, 0);
    chk("R11 offset reg 0 reset value", q_data, 7);
    rd_pulse(0, 0);
    chk("R11 offset reg 1 reset value", q_data, 7);
    wr_word(9'h03C, 0, 0, 0);
    wr_word(9'h1C3, 0, 0, 0);
    repeat (4) @(negedge rd_clk);
    chk("R3 load does not fill FIFO", empty_n, 0);
    rd_pulse(0, 0);
    chk("R4 offset reg 0 readback", q_data, 9'h03C);
    rd_pulse(0, 0);
    chk("R4 offset reg 1 readback", q_data, 9'h1C3);
    wr_word(9'h077, 0, 1, 1);
    repeat (4) @(negedge rd_clk);
    chk("R3 load mode FIFO write", empty_n, 1);
    rd_pulse(0, 0);
    chk("R3 load mode FIFO word", q_data, 9'h077);
    chk("R4 offset reads did not pop", empty_n, 0);
  endtask

  initial begin
    t_reset_state();
    t_first_word();
    t_dual_enable();
    t_full();
    t_load_mode();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge wr_clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule